// File: doc/BRIEF.md
# Four-Slot Edge Timestamp Capture Unit

This block is an input-capture peripheral. It keeps a free-running 32-bit up-counter and watches one external input. Each time the input makes the edge chosen for the current slot, the counter value is stored in that slot's capture register. Slots are filled in turn, from slot 0 up to a programmable last slot. The block keeps a flag for every slot and one for counter wrap-around. It also keeps a per-event enable mask and a global interrupt latch, and it combines them into a single interrupt line.

Software reaches every register over a plain 32-bit word bus: byte address, write strobe, write data and combinational read data. The main uses are measuring pulse widths, periods and duty cycles. Software does this by subtracting the stamps held in successive slots.

Top module: `tscap_top`

## Requirements
- R1: After reset, the counter, the control word, every flag, every enable, the latch and `irq` are all zero. Address 0x5C reads the identification constant `ID_VALUE`.
- R2: While control bit 20 is 1, the counter at 0x00 rises by exactly one per clock. A bus write to 0x00 loads the written value in place of that step.
- R3: While control bit 20 is 0, the counter keeps its value.
- R4: The input passes through a two-flop synchroniser. Each slot i has its own polarity bit at control bit 2*i: 0 selects a rising edge and 1 selects a falling edge. A qualifying edge stores the counter value in slot i (address 0x08+4*i) and moves on to the next slot. An edge of the other polarity stores nothing and sets no flag.
- R5: In continuous mode (control bit 16 = 0), the slot after the stop slot (control bits 18:17) is slot 0.
- R6: In one-shot mode (control bit 16 = 1), capture stops once the stop slot has been stored. Writing control bit 8 from 0 to 1 restarts the sequence at slot 0.
- R7: While control bit 8 is 0, edges store nothing and set no flag.
- R8: A counter step from 0xFFFFFFFF to 0 sets the flag of event 4.
- R9: Address 0x2C reads as follows. The flag of event i (slots 0..3 are events 0..3, wrap is event 4) is at bit i+17. The global latch is at bit 16. The enable of event i is at bit i+1, and only these enable bits are writable.
- R10: At 0x30, writing 1 to bit i+1 clears the flag of event i, and writing 1 to bit 0 clears the latch. Zero bits change nothing. A flag that is being set in the same cycle as its clear stays set.
- R11: `irq` is high exactly when the latch is set and at least one enabled flag is set. The latch sets in every cycle in which an enabled flag is pending, unless that cycle clears the latch.
- R12: A bus write to 0x08+4*i loads capture slot i directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | 1 | Asynchronous capture input |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The embedded assertions check the following on every cycle: the counter's one-step advance and its freeze, the wrap flag, the slot advance, the one-shot halt, the rule that a flag set beats its clear, and the latch clear. The bench scenarios cover the rest. These are the per-slot polarity filtering, the wrap of the slot index at a programmed stop value, and the re-arm of one-shot mode through the load enable. The scenarios also cover the cycle-exact drop and return of `irq` around a latch clear and the stamp differences that a running counter produces. A seeded random phase mixes polarities with counter values and compares all four slots against a model.

// File: rtl/tscap_pkg.sv
package tscap_pkg;

    localparam int DW       = 32;
    localparam int NCAP     = 4;
    localparam int NEVT     = NCAP + 1;
    localparam int SLOT_W   = $clog2(NCAP);

    // register offsets
    localparam logic [7:0] A_CNT  = 8'h00;
    localparam logic [7:0] A_CAP0 = 8'h08;
    localparam logic [7:0] A_CTRL = 8'h28;
    localparam logic [7:0] A_IFLG = 8'h2C;
    localparam logic [7:0] A_CLR  = 8'h30;
    localparam logic [7:0] A_ID   = 8'h5C;

    // control field positions
    localparam int B_LOAD    = 8;
    localparam int B_ONESHOT = 16;
    localparam int B_STOP    = 17;
    localparam int B_RUN     = 20;

    // flag/enable register positions
    localparam int B_EN      = 1;
    localparam int B_LATCH   = 16;
    localparam int B_FLAG    = 17;

    typedef struct packed {
        logic              run;
        logic [SLOT_W-1:0] stop;
        logic              oneshot;
        logic              load_en;
        logic [NCAP-1:0]   pol;
    } ctrl_t;

    function automatic logic [DW-1:0] ctrl_pack(input ctrl_t c);
        logic [DW-1:0] w;
        w = '0;
        for (int i = 0; i < NCAP; i++) w[2*i] = c.pol[i];
        w[B_LOAD]                   = c.load_en;
        w[B_ONESHOT]                = c.oneshot;
        w[B_STOP +: SLOT_W]         = c.stop;
        w[B_RUN]                    = c.run;
        return w;
    endfunction

    function automatic logic [7:0] cap_offset(input int unsigned i);
        return 8'(A_CAP0 + 4 * i);
    endfunction

endpackage

// File: rtl/tscap_edge.sv
module tscap_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    // SYNC_STAGES synchroniser flops plus one history flop
    logic [SYNC_STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SYNC_STAGES-1:0], din};
    end

    assign rise =  sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    assign fall = ~sh_q[SYNC_STAGES-1] &  sh_q[SYNC_STAGES];

endmodule

// File: rtl/tscap_seq.sv
module tscap_seq
    import tscap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCAP-1:0]   pol,
    input  logic [SLOT_W-1:0] stop,
    input  logic              oneshot,
    input  logic              load_en,
    input  logic              rearm,
    input  logic              rise,
    input  logic              fall,
    output logic              fire,
    output logic [SLOT_W-1:0] slot
);
    logic [SLOT_W-1:0] idx_q;
    logic              armed_q;
    logic              hit;

    assign hit  = pol[idx_q] ? fall : rise;
    assign fire = load_en & armed_q & hit;
    assign slot = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            armed_q <= 1'b1;
        end else if (rearm) begin
            idx_q   <= '0;
            armed_q <= 1'b1;
        end else if (fire) begin
            if (idx_q == stop) begin
                idx_q <= '0;
                if (oneshot) armed_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (rst)
        (fire && oneshot && idx_q == stop && !rearm) |=> !armed_q);   // R6
    AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (fire && idx_q != stop && !rearm) |=> idx_q == $past(idx_q) + 1'b1);   // R4
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (fire && idx_q == stop && !rearm) |=> idx_q == '0);   // R5

endmodule

// File: rtl/tscap_irq.sv
module tscap_irq
    import tscap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NEVT-1:0] set_i,
    input  logic [NEVT-1:0] clr_i,
    input  logic            clr_latch,
    input  logic [NEVT-1:0] en_i,
    output logic [NEVT-1:0] flags,
    output logic            latch,
    output logic            irq
);
    logic [NEVT-1:0] flags_q;
    logic            latch_q;
    logic            pending;

    assign pending = |(flags_q & en_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            latch_q <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~clr_i) | set_i;
            if (clr_latch)    latch_q <= 1'b0;
            else if (pending) latch_q <= 1'b1;
        end
    end

    assign flags = flags_q;
    assign latch = latch_q;
    assign irq   = latch_q & pending;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));   // R10
    AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr_latch |=> !latch_q);   // R11

endmodule

// File: rtl/tscap_top.sv
module tscap_top
    import tscap_pkg::*;
#(
    parameter logic [31:0] ID_VALUE    = 32'h7CA5_0104,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_in,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wen,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    ctrl_t                     ctrl_q;
    logic [NEVT-1:0]           en_q;
    logic [DW-1:0]             cnt_q;
    logic [NCAP-1:0][DW-1:0]   cap_q;

    logic                      rise, fall, fire, rearm;
    logic [SLOT_W-1:0]         slot;
    logic                      wr_cnt, wr_ctrl, wr_en, wr_clr, ovf_set;
    logic [NCAP-1:0]           wr_cap, cap_set;
    logic [NEVT-1:0]           flags, clr_vec;
    logic                      latch;

    assign wr_cnt  = bus_wen && bus_addr == A_CNT;
    assign wr_ctrl = bus_wen && bus_addr == A_CTRL;
    assign wr_en   = bus_wen && bus_addr == A_IFLG;
    assign wr_clr  = bus_wen && bus_addr == A_CLR;
    assign rearm   = wr_ctrl && bus_wdata[B_LOAD] && !ctrl_q.load_en;

    for (genvar i = 0; i < NCAP; i++) begin : g_slot
        assign wr_cap[i]  = bus_wen && bus_addr == cap_offset(i);
        assign cap_set[i] = fire && slot == SLOT_W'(i);
    end

    // control and enable registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            en_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                for (int i = 0; i < NCAP; i++) ctrl_q.pol[i] <= bus_wdata[2*i];
                ctrl_q.load_en <= bus_wdata[B_LOAD];
                ctrl_q.oneshot <= bus_wdata[B_ONESHOT];
                ctrl_q.stop    <= bus_wdata[B_STOP +: SLOT_W];
                ctrl_q.run     <= bus_wdata[B_RUN];
            end
            if (wr_en) en_q <= bus_wdata[B_EN +: NEVT];
        end
    end

    // timestamp counter
    assign ovf_set = ctrl_q.run && !wr_cnt && (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (wr_cnt)      cnt_q <= bus_wdata;
        else if (ctrl_q.run)  cnt_q <= cnt_q + 1'b1;
    end

    // capture slots: a hardware stamp takes priority over a bus write
    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else begin
            for (int i = 0; i < NCAP; i++) begin
                if (cap_set[i])     cap_q[i] <= cnt_q;
                else if (wr_cap[i]) cap_q[i] <= bus_wdata;
            end
        end
    end

    assign clr_vec = wr_clr ? bus_wdata[1 +: NEVT] : '0;

    tscap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (cap_in),
        .rise (rise),
        .fall (fall)
    );

    tscap_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .pol     (ctrl_q.pol),
        .stop    (ctrl_q.stop),
        .oneshot (ctrl_q.oneshot),
        .load_en (ctrl_q.load_en),
        .rearm   (rearm),
        .rise    (rise),
        .fall    (fall),
        .fire    (fire),
        .slot    (slot)
    );

    tscap_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .set_i     ({ovf_set, cap_set}),
        .clr_i     (clr_vec),
        .clr_latch (wr_clr && bus_wdata[0]),
        .en_i      (en_q),
        .flags     (flags),
        .latch     (latch),
        .irq       (irq)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CNT:  bus_rdata = cnt_q;
            A_CTRL: bus_rdata = ctrl_pack(ctrl_q);
            A_IFLG: begin
                bus_rdata[B_FLAG +: NEVT] = flags;
                bus_rdata[B_LATCH]        = latch;
                bus_rdata[B_EN +: NEVT]   = en_q;
            end
            A_ID:   bus_rdata = ID_VALUE;
            default: begin
                for (int i = 0; i < NCAP; i++)
                    if (bus_addr == cap_offset(i)) bus_rdata = cap_q[i];
            end
        endcase
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && !wr_cnt) |=> cnt_q == $past(cnt_q) + 1'b1);   // R2
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !wr_cnt) |=> $stable(cnt_q));   // R3
    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && !wr_cnt && cnt_q == '1) |=> flags[NCAP]);   // R8
    AST_NO_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.load_en && !wr_cap[0]) |=> $stable(cap_q[0]));   // R7

endmodule

// File: tb/tscap_top_bench.sv
`timescale 1ns/1ps
module tscap_top_bench;
    localparam logic [31:0] ID = 32'h7CA5_0104;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_in = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tscap_top u_tscap_top (
        .clk(clk), .rst(rst), .cap_in(cap_in), .bus_addr(bus_addr),
        .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] cw(input logic [3:0] pol, input bit load,
                                       input bit one, input logic [1:0] stop, input bit run);
        logic [31:0] w = '0;
        for (int i = 0; i < 4; i++) w[2*i] = pol[i];
        w[8] = load; w[16] = one; w[18:17] = stop; w[20] = run;
        return w;
    endfunction

    function automatic logic [7:0] cap_a(input int i);
        return 8'(8'h08 + 4 * i);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic drive_in(input logic v);
        cap_in = v;
        tick(6);
    endtask

    initial begin
        #750000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        logic [31:0] mcap [4];
        logic [3:0]  rpol;
        int          midx;
        void'($urandom(32'd20240611));

        tick(4);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        chk_rd("R1 counter", 8'h00, 32'h0);
        chk_rd("R1 control", 8'h28, 32'h0);
        chk_rd("R1 flags", 8'h2C, 32'h0);
        chk_rd("R1 id", 8'h5C, ID);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 counting and load
        wr(8'h28, cw(4'h0, 0, 0, 2'd0, 1));
        rd(8'h00, a); tick(17); rd(8'h00, b);
        chk("R2 step count", b - a, 32'd17);
        wr(8'h00, 32'd100);
        chk_rd("R2 load while running", 8'h00, 32'd100);

        // R3 frozen
        wr(8'h28, 32'h0);
        rd(8'h00, a); tick(10); rd(8'h00, b);
        chk("R3 frozen", b, a);

        // R4 polarity per slot: slot1 and slot2 falling
        wr(8'h28, cw(4'b0110, 1, 0, 2'd3, 0));
        wr(8'h00, 32'h111); drive_in(1'b1);
        wr(8'h00, 32'h222); drive_in(1'b0);
        chk_rd("R4 slot0 rising", cap_a(0), 32'h111);
        chk_rd("R4 slot1 falling", cap_a(1), 32'h222);
        chk_rd("R9 capture flags", 8'h2C, 32'h0006_0000);
        chk("R11 irq masked when disabled", 32'(irq), 32'h0);
        wr(8'h00, 32'h333); drive_in(1'b1);
        chk_rd("R4 wrong edge ignored slot2", cap_a(2), 32'h0);
        chk_rd("R4 wrong edge no flag", 8'h2C, 32'h0006_0000);
        drive_in(1'b0);
        chk_rd("R4 slot2 falling", cap_a(2), 32'h333);
        wr(8'h00, 32'h444); drive_in(1'b1);
        chk_rd("R4 slot3 rising", cap_a(3), 32'h444);
        wr(8'h00, 32'h555); drive_in(1'b0); drive_in(1'b1);
        chk_rd("R5 wrap to slot0", cap_a(0), 32'h555);

        // R5 stop value 1, continuous
        wr(8'h30, 32'h3F);
        wr(8'h28, 32'h0);
        wr(8'h28, cw(4'h0, 1, 0, 2'd1, 0));
        drive_in(1'b0);
        wr(8'h00, 32'hA0); drive_in(1'b1); drive_in(1'b0);
        wr(8'h00, 32'hA1); drive_in(1'b1); drive_in(1'b0);
        wr(8'h00, 32'hA2); drive_in(1'b1); drive_in(1'b0);
        chk_rd("R5 stop1 slot0", cap_a(0), 32'hA2);
        chk_rd("R5 stop1 slot1", cap_a(1), 32'hA1);
        chk_rd("R5 slot2 untouched", cap_a(2), 32'h333);

        // R6 one-shot
        wr(8'h28, 32'h0);
        wr(8'h28, cw(4'h0, 1, 1, 2'd1, 0));
        wr(8'h00, 32'hB0); drive_in(1'b1); drive_in(1'b0);
        wr(8'h00, 32'hB1); drive_in(1'b1); drive_in(1'b0);
        wr(8'h00, 32'hB2); drive_in(1'b1); drive_in(1'b0);
        chk_rd("R6 halted slot0", cap_a(0), 32'hB0);
        chk_rd("R6 slot1", cap_a(1), 32'hB1);
        wr(8'h28, 32'h0);
        wr(8'h28, cw(4'h0, 1, 1, 2'd1, 0));
        wr(8'h00, 32'hB3); drive_in(1'b1); drive_in(1'b0);
        chk_rd("R6 rearm restarts slot0", cap_a(0), 32'hB3);

        // R7 load disabled
        wr(8'h28, 32'h0);
        wr(8'h30, 32'h3F);
        wr(8'h00, 32'hC0); drive_in(1'b1); drive_in(1'b0);
        chk_rd("R7 no store", cap_a(0), 32'hB3);
        chk_rd("R7 no flag", 8'h2C, 32'h0);

        // R12 direct slot write
        wr(cap_a(2), 32'hDEAD_BEEF);
        chk_rd("R12 slot write", cap_a(2), 32'hDEAD_BEEF);

        // R4 running-counter stamp difference
        wr(8'h28, cw(4'b0010, 1, 0, 2'd3, 1));
        drive_in(1'b1); tick(10); drive_in(1'b0);
        rd(cap_a(0), a); rd(cap_a(1), b);
        chk("R4 stamp difference", b - a, 32'd16);

        // R8 / R9 / R11 overflow and interrupt
        wr(8'h28, 32'h0);
        wr(8'h30, 32'h3F);
        wr(8'h2C, 32'h20);
        wr(8'h00, 32'hFFFF_FFFD);
        wr(8'h28, cw(4'h0, 0, 0, 2'd0, 1));
        tick(6);
        wr(8'h28, 32'h0);
        chk_rd("R8 R9 overflow flag", 8'h2C, 32'h0021_0020);
        chk("R11 irq on overflow", 32'(irq), 32'h1);
        wr(8'h30, 32'h1);
        chk("R11 irq drops on latch clear", 32'(irq), 32'h0);
        tick(1);
        chk("R11 latch re-asserts", 32'(irq), 32'h1);
        wr(8'h30, 32'h0);
        chk_rd("R10 zero write no effect", 8'h2C, 32'h0021_0020);
        wr(8'h30, 32'h21);
        chk_rd("R10 clear flag and latch", 8'h2C, 32'h0000_0020);
        chk("R10 irq after clear", 32'(irq), 32'h0);

        // R4 random polarity run, stop 3, continuous
        for (int i = 0; i < 4; i++) rd(cap_a(i), mcap[i]);
        rpol = 4'($urandom);
        wr(8'h28, 32'h0);
        wr(8'h28, cw(rpol, 1, 0, 2'd3, 0));
        midx = 0;
        for (int k = 0; k < 24; k++) begin
            logic [31:0] v;
            logic        nv;
            v  = $urandom;
            nv = ~cap_in;
            wr(8'h00, v);
            drive_in(nv);
            if ((rpol[midx] && !nv) || (!rpol[midx] && nv)) begin
                mcap[midx] = v;
                midx = (midx + 1) % 4;
            end
        end
        for (int i = 0; i < 4; i++) chk_rd("R4 random slot", cap_a(i), mcap[i]);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule